// File: doc/BRIEF.md
# I2C Target Protocol Engine with High-Speed Entry

This block is the bus-side engine of an I2C target. It samples SCL and SDA on the system clock through a synchroniser and a sample-count glitch filter. It finds START, repeated START and STOP, and compares the first byte of each transfer with its own 7-bit address. The upper five address bits are fixed at `01010`. The lower two bits come from configuration. Bytes written by the controller come out on a one-cycle `rx_valid_o` strobe. Bytes to be read are fetched from the internal logic with a `tx_req_o`/`tx_ack_i` handshake.

The engine has no SCL output and therefore never stretches the clock. The internal logic must answer a byte request within half an SCL low phase. Standard and fast mode need no setting, because only the SCL rate differs between them.

High-speed mode is entered with the master-code byte followed by a repeated START, and only when it is enabled. Entry raises `hs_pad_o`, which reconfigures the pads, and the next STOP lowers it. A reserved device-ID address can be enabled, and it returns a fixed three-byte identifier. The configuration inputs are copied into active registers only while `busy_o` is low, so a transfer in progress never sees them change.

Top module: `i2c_tgt_hs`

## Requirements
- R1: A first byte whose upper seven bits equal {5'b01010, active address low bits} is ACKed (SDA held low during the ninth clock). Any other non-reserved address is NACKed, and SDA is never driven while the engine is idle.
- R2: A first byte whose upper five bits are 5'b11110 (a 10-bit address header) is always NACKed.
- R3: A first byte of the form 8'b00001xxx (master code) is always NACKed. If high-speed enable is active, the following repeated START drives `hs_pad_o` high. `hs_pad_o` returns low on the next STOP, and it stays low when high-speed enable is inactive.
- R4: After high-speed entry, the engine's own address is ACKed and data transfer proceeds normally.
- R5: In a write, each data byte is received MSB first and ACKed, and it is presented on `rx_data_o` with a single-cycle `rx_valid_o` pulse.
- R6: In a read, `tx_req_o` rises before each byte and the byte taken with `tx_ack_i` is sent MSB first. If no byte is supplied, 8'hFF is sent. After a controller NACK, SDA stays released.
- R7: With device-ID enabled, address 7'b1111100 is ACKed and a read returns the three `DEV_ID` bytes, most significant first. With device-ID disabled, that address is NACKed.
- R8: `busy_o` rises once a matching address has been received and stays high until STOP. A NACKed address clears it. It is low after reset.
- R9: Configuration inputs reach the active registers only while `busy_o` is low. A change made during a busy transfer has no effect on address matching until the transfer ends.
- R10: A `soft_rst_i` pulse with soft-reset enable active returns the engine to idle with SDA released, `busy_o` low and `hs_pad_o` low. With soft-reset enable inactive, the pulse has no effect.
- R11: An SDA pulse shorter than `FILT_CYC` system clocks while SCL is high is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| hs_pad_o | output | 1 | High-speed pad configuration select |
| busy_o | output | 1 | Transfer to this target in progress |
| cfg_addr_lo_i | input | 2 | Requested low address bits |
| cfg_hs_en_i | input | 1 | Requested high-speed enable |
| cfg_srst_en_i | input | 1 | Requested soft-reset enable |
| cfg_id_en_i | input | 1 | Requested device-ID enable |
| soft_rst_i | input | 1 | Soft reset request |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| tx_req_o | output | 1 | Next transmit byte wanted |
| tx_ack_i | input | 1 | Transmit byte supplied |
| tx_data_i | input | 8 | Transmit byte |

## Verification
The bench builds the engine with `FILT_CYC` = 4 and overrides `DEV_ID` with 24'h5A1E87, so the identifier bytes differ from one another and from the padding value 8'hFF. With a four-sample filter, a two-clock SDA pulse during SCL high tests glitch rejection, and a bench quarter-bit of 12 clocks leaves room for the filter delay before the controller moves SDA. These settings make it possible to check the master-code and repeated-START entry, holding the configuration across a repeated START, and a soft reset while the engine is driving a data bit low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam logic [4:0] ADDR_HI     = 5'b01010;
    localparam logic [4:0] TENBIT_HDR  = 5'b11110;
    localparam logic [4:0] MCODE_HDR   = 5'b00001;
    localparam logic [6:0] DEVID_ADDR  = 7'b1111100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_RD, ST_MACK, ST_WAIT
    } st_e;

    typedef struct packed {
        logic [1:0] addr_lo;
        logic       hs_en;
        logic       srst_en;
        logic       id_en;
    } cfg_t;

    typedef struct packed {
        st_e        st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       ack;
        logic       rd;
        logic       is_id;
        logic [1:0] id_idx;
        logic       mc;
        logic       hs;
        logic       busy;
        logic       oe;
        logic       rxv;
        logic       txr;
        logic [7:0] tx_buf;
        logic       scl_p;
        logic       sda_p;
    } ctx_t;

endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

    logic [1:0]       sync_d, sync_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             out_d, out_q;

    always_comb begin
        sync_d = {sync_q[0], din_i};
        cnt_d  = '0;
        out_d  = out_q;
        if (sync_q[1] != out_q) begin
            if (cnt_q == CNT_LAST) begin
                out_d = sync_q[1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign dout_o = out_q;
endmodule

// File: rtl/i2c_tgt_cfg.sv
module i2c_tgt_cfg
    import i2c_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  cfg_t req_i,
    output cfg_t act_o
);
    cfg_t act_d, act_q;

    always_comb begin
        act_d = busy_i ? act_q : req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act_o = act_q;
endmodule

// File: rtl/i2c_tgt_hs.sv
module i2c_tgt_hs
    import i2c_tgt_pkg::*;
#(
    parameter int          FILT_CYC = 4,
    parameter logic [23:0] DEV_ID   = 24'h0A52C3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       hs_pad_o,
    output logic       busy_o,
    input  logic [1:0] cfg_addr_lo_i,
    input  logic       cfg_hs_en_i,
    input  logic       cfg_srst_en_i,
    input  logic       cfg_id_en_i,
    input  logic       soft_rst_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       tx_req_o,
    input  logic       tx_ack_i,
    input  logic [7:0] tx_data_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, filt;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;
    cfg_t req, act;
    ctx_t d, q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_tgt_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (raw[g]),
            .dout_o (filt[g])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    assign req = '{addr_lo: cfg_addr_lo_i, hs_en: cfg_hs_en_i,
                   srst_en: cfg_srst_en_i, id_en: cfg_id_en_i};

    i2c_tgt_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (q.busy),
        .req_i  (req),
        .act_o  (act)
    );

    assign scl_rise  = scl_f & ~q.scl_p;
    assign scl_fall  = ~scl_f & q.scl_p;
    assign start_det = scl_f & q.scl_p & q.sda_p & ~sda_f;
    assign stop_det  = scl_f & q.scl_p & ~q.sda_p & sda_f;

    function automatic ctx_t idle_ctx();
        ctx_t c;
        c.st     = ST_IDLE;
        c.cnt    = '0;
        c.sh     = '0;
        c.ack    = 1'b0;
        c.rd     = 1'b0;
        c.is_id  = 1'b0;
        c.id_idx = '0;
        c.mc     = 1'b0;
        c.hs     = 1'b0;
        c.busy   = 1'b0;
        c.oe     = 1'b0;
        c.rxv    = 1'b0;
        c.txr    = 1'b0;
        c.tx_buf = 8'hFF;
        c.scl_p  = 1'b1;
        c.sda_p  = 1'b1;
        return c;
    endfunction

    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return DEV_ID[23:16];
            2'd1:    return DEV_ID[15:8];
            2'd2:    return DEV_ID[7:0];
            default: return 8'hFF;
        endcase
    endfunction

    logic [7:0] in_byte, out_byte;
    logic       hit_own, hit_id, is_mc;

    assign in_byte  = {q.sh[6:0], sda_f};
    assign hit_own  = (in_byte[7:1] == {ADDR_HI, act.addr_lo});
    assign hit_id   = act.id_en && (in_byte[7:1] == DEVID_ADDR);
    assign is_mc    = (in_byte[7:3] == MCODE_HDR);
    assign out_byte = q.is_id ? id_byte(q.id_idx) : q.tx_buf;

    always_comb begin
        d     = q;
        d.rxv = 1'b0;
        if (tx_ack_i && q.txr) begin
            d.tx_buf = tx_data_i;
            d.txr    = 1'b0;
        end
        if (soft_rst_i && act.srst_en) begin
            d = idle_ctx();
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.busy = 1'b0;
            d.hs   = 1'b0;
            d.mc   = 1'b0;
            d.oe   = 1'b0;
            d.txr  = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            if (q.mc) begin
                d.hs = 1'b1;
                d.mc = 1'b0;
            end
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = in_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.ack    = hit_own | hit_id;
                            d.busy   = hit_own | hit_id;
                            d.rd     = in_byte[0];
                            d.is_id  = hit_id;
                            d.id_idx = '0;
                            if (is_mc && act.hs_en) d.mc = 1'b1;
                            if (hit_own && in_byte[0]) begin
                                d.txr    = 1'b1;
                                d.tx_buf = 8'hFF;
                            end
                        end
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.ack) begin
                            d.st = ST_ACK;
                            d.oe = 1'b1;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st = ST_RD;
                            d.sh = out_byte;
                            d.oe = ~out_byte[7];
                            if (q.is_id && q.id_idx != 2'd3)
                                d.id_idx = q.id_idx + 2'd1;
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh  = in_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) d.rxv = ~q.is_id;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7 && !q.is_id) begin
                            d.txr    = 1'b1;
                            d.tx_buf = 8'hFF;
                        end
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st  = ST_MACK;
                            d.cnt = '0;
                            d.oe  = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.cnt = 4'd1;
                        d.ack = ~sda_f;
                    end else if (scl_fall && q.cnt == 4'd1) begin
                        d.cnt = '0;
                        if (q.ack) begin
                            d.st = ST_RD;
                            d.sh = out_byte;
                            d.oe = ~out_byte[7];
                            if (q.is_id && q.id_idx != 2'd3)
                                d.id_idx = q.id_idx + 2'd1;
                        end else begin
                            d.st  = ST_WAIT;
                            d.oe  = 1'b0;
                            d.txr = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        d.scl_p = scl_f;
        d.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= idle_ctx();
        else        q <= d;
    end

    assign sda_oe_o   = q.oe;
    assign hs_pad_o   = q.hs;
    assign busy_o     = q.busy;
    assign rx_valid_o = q.rxv;
    assign rx_data_o  = q.sh;
    assign tx_req_o   = q.txr;
endmodule

// File: rtl/i2c_tgt_hs_chk.sv
module i2c_tgt_hs_chk
    import i2c_tgt_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input st_e  st_i,
    input logic mc_i,
    input logic start_i,
    input logic stop_i,
    input cfg_t act_i,
    input logic soft_rst_i,
    input logic sda_oe_i,
    input logic busy_i,
    input logic hs_i,
    input logic rxv_i
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_IDLE) |-> !sda_oe_i);

    // R3
    hs_needs_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_i) |-> $past(mc_i) && $past(start_i));

    // R3
    stop_drops_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !soft_rst_i) |=> !hs_i);

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxv_i |=> !rxv_i);

    // R6
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_WAIT) |-> !sda_oe_i);

    // R8
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_i);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(act_i));

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && act_i.srst_en) |=> (!sda_oe_i && !busy_i && !hs_i));
endmodule

bind i2c_tgt_hs i2c_tgt_hs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_i       (q.st),
    .mc_i       (q.mc),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .act_i      (act),
    .soft_rst_i (soft_rst_i),
    .sda_oe_i   (sda_oe_o),
    .busy_i     (busy_o),
    .hs_i       (hs_pad_o),
    .rxv_i      (rx_valid_o)
);

// File: tb/i2c_tgt_hs_tb.sv
module i2c_tgt_hs_tb;
    localparam int CLK_NS = 10;
    localparam int Q      = 12;
    localparam logic [23:0] ID = 24'h5A1E87;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, hs_pad, busy, rx_valid, tx_req;
    logic [7:0] rx_data;
    logic [1:0] cfg_addr_lo = 2'b01;
    logic cfg_hs_en = 1'b0, cfg_srst_en = 1'b0, cfg_id_en = 1'b0;
    logic soft_rst = 1'b0, tx_ack = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_q[$];

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_NS/2) clk = ~clk;

    i2c_tgt_hs #(.FILT_CYC(4), .DEV_ID(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .hs_pad_o(hs_pad), .busy_o(busy),
        .cfg_addr_lo_i(cfg_addr_lo), .cfg_hs_en_i(cfg_hs_en),
        .cfg_srst_en_i(cfg_srst_en), .cfg_id_en_i(cfg_id_en),
        .soft_rst_i(soft_rst), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .tx_req_o(tx_req), .tx_ack_i(tx_ack), .tx_data_i(tx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bit_x(input logic b, output logic r);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        r = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_x(b[i], r);
        bit_x(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] dv);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, r);
            dv[i] = r;
        end
        bit_x(~mack, r);
    endtask

    // scoreboard monitor for received bytes
    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_exp.size() == 0) begin
                chk(1'b0, "R5 unexpected byte", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = rx_exp.pop_front();
                chk(rx_data == e, "R5 rx data", rx_data, e);
            end
        end
    end

    // transmit byte supplier
    always @(negedge clk) begin
        if (tx_req && !tx_ack) begin
            tx_data = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
            tx_ack  = 1'b1;
        end else begin
            tx_ack  = 1'b0;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] rv;
        tick(4);
        rst_n = 1'b1;
        tick(8);
        // R8 reset state
        chk(!busy && !sda_oe && !hs_pad && !tx_req, "R8 reset", {busy, sda_oe, hs_pad, tx_req}, 0);

        // R1 / R5 / R11: write to own address 0101001
        bus_start();
        wbyte(8'h52, a);
        chk(a, "R1 own addr ack", a, 1);
        chk(busy, "R8 busy after match", busy, 1);
        rx_exp.push_back(8'hA5);
        wbyte(8'hA5, a);
        chk(a, "R5 data ack", a, 1);
        rx_exp.push_back(8'h3C);
        wbyte(8'h3C, a);
        chk(a, "R5 data ack", a, 1);
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2); sda_m = 1'b0; tick(Q);
        chk(busy, "R11 glitch not stop", busy, 1);
        scl_m = 1'b0; tick(Q);
        bus_stop();
        chk(!busy, "R8 busy after stop", busy, 0);
        chk(rx_exp.size() == 0, "R5 all bytes seen", rx_exp.size(), 0);

        // R1 wrong address
        bus_start();
        wbyte(8'h54, a);
        chk(!a, "R1 other addr nack", a, 0);
        chk(!busy, "R8 nack no busy", busy, 0);
        bus_stop();

        // R2 10-bit header
        bus_start();
        wbyte(8'hF2, a);
        chk(!a, "R2 10-bit nack", a, 0);
        bus_stop();

        // R6 read
        tx_q.push_back(8'h96);
        tx_q.push_back(8'h0F);
        bus_start();
        wbyte(8'h53, a);
        chk(a, "R6 read addr ack", a, 1);
        rbyte(1'b1, rv);
        chk(rv == 8'h96, "R6 first byte", rv, 8'h96);
        rbyte(1'b0, rv);
        chk(rv == 8'h0F, "R6 second byte", rv, 8'h0F);
        rbyte(1'b0, rv);
        chk(rv == 8'hFF, "R6 released after nack", rv, 8'hFF);
        bus_stop();

        // R7 device ID disabled then enabled
        bus_start();
        wbyte(8'hF9, a);
        chk(!a, "R7 id disabled nack", a, 0);
        bus_stop();
        cfg_id_en = 1'b1;
        tick(4);
        bus_start();
        wbyte(8'hF9, a);
        chk(a, "R7 id ack", a, 1);
        rbyte(1'b1, rv);
        chk(rv == ID[23:16], "R7 id byte0", rv, ID[23:16]);
        rbyte(1'b1, rv);
        chk(rv == ID[15:8], "R7 id byte1", rv, ID[15:8]);
        rbyte(1'b0, rv);
        chk(rv == ID[7:0], "R7 id byte2", rv, ID[7:0]);
        bus_stop();

        // R3 master code without high-speed enable
        bus_start();
        wbyte(8'h08, a);
        chk(!a, "R3 mcode nack", a, 0);
        bus_start();
        chk(!hs_pad, "R3 no hs when disabled", hs_pad, 0);
        bus_stop();

        // R3 / R4 high-speed entry
        cfg_hs_en = 1'b1;
        tick(4);
        bus_start();
        wbyte(8'h0B, a);
        chk(!a, "R3 mcode nack hs", a, 0);
        chk(!hs_pad, "R3 hs low before rstart", hs_pad, 0);
        bus_start();
        chk(hs_pad, "R3 hs after rstart", hs_pad, 1);
        wbyte(8'h52, a);
        chk(a, "R4 addr ack in hs", a, 1);
        rx_exp.push_back(8'h77);
        wbyte(8'h77, a);
        chk(a, "R4 data ack in hs", a, 1);
        bus_stop();
        chk(!hs_pad, "R3 hs low after stop", hs_pad, 0);

        // R9 configuration held while busy
        bus_start();
        wbyte(8'h52, a);
        chk(a && busy, "R9 busy transfer", {a, busy}, 3);
        cfg_addr_lo = 2'b10;
        tick(4);
        bus_start();
        wbyte(8'h54, a);
        chk(!a, "R9 new addr ignored while busy", a, 0);
        bus_stop();
        bus_start();
        wbyte(8'h54, a);
        chk(a, "R9 new addr after idle", a, 1);

        // R10 soft reset ignored when not enabled
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0; tick(2);
        chk(busy, "R10 ignored when disabled", busy, 1);
        bus_stop();
        cfg_srst_en = 1'b1;
        tick(4);
        tx_q.push_back(8'h00);
        bus_start();
        wbyte(8'h55, a);
        chk(a, "R10 read addr ack", a, 1);
        bit_x(1'b1, a);
        chk(!a && sda_oe, "R10 driving before reset", {a, sda_oe}, 1);
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0; tick(2);
        chk(!sda_oe && !busy && !hs_pad, "R10 soft reset idle", {sda_oe, busy, hs_pad}, 0);
        bus_stop();

        tick(10);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule